// File: doc/BRIEF.md
# I2C Transmit Bit Timing Engine

This block sequences the low phase of the serial clock for one data bit that an I2C transmitter sends. It watches the shared clock line through a two-stage synchronizer and an optional glitch filter, and reacts to each falling edge it detects. It pulls the clock line low, waits a programmable data-hold interval, and then places the next data bit on the data line. After that it keeps the clock low for a programmable data-setup interval and then lets the line go.

All intervals are counted on a prescaled time base. If the next bit is not ready when the hold interval ends, the block keeps the clock low until the bit arrives. This is clock stretching. After it releases the clock, the block waits until the line actually reads high before it accepts another falling edge, so any other device on the bus may also stretch. Both outputs are open-drain enables: asserted means the line is pulled low.

Top module: `i2c_bit_timer`

## Requirements
- R1: A synchronous active-low reset releases both line enables and clears the taken pulse on the first clock edge at which reset is sampled low. No falling edge is seen while reset is held.
- R2: With a filter length of 0, `sclOe` asserts on the third rising edge after `sclIn` is first sampled low. A filter length F delays this by F more cycles.
- R3: With a filter length F greater than 0, a low pulse on `sclIn` that lasts fewer than F synchronized cycles is ignored and `sclOe` stays deasserted.
- R4: Let P be the prescale value and H the hold count, and let `dataValid` be high. Then `bitTaken` and the new SDA level appear H*(P+1)+1 cycles after the first cycle of `sclOe`. With H=0 this is one cycle.
- R5: The data line encoding is `sdaOe`=1 for a data bit of 0 and `sdaOe`=0 for a data bit of 1. `sdaOe` changes only in a cycle where `bitTaken` is high.
- R6: `bitTaken` is high for exactly one cycle per bit, and only while `sclOe` is asserted.
- R7: `sclOe` deasserts (S+1)*(P+1)+1 cycles after the `bitTaken` cycle, where S is the setup count.
- R8: If `dataValid` is low when the hold interval ends, `sclOe` stays asserted and `sdaOe` keeps its value. Once `dataValid` is sampled high, `bitTaken` and the new level follow one cycle later, and the setup interval of R7 counts from that point.
- R9: After it releases the clock, the block starts no new bit while another device holds the line low. It accepts the next falling edge only after the line has read high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset |
| sclIn | input | 1 | Raw clock line level (asynchronous) |
| prescale | input | 4 | Time base divider; one tick every prescale+1 clocks |
| holdCount | input | 4 | Data-hold interval in ticks (0 = none) |
| setupCount | input | 4 | Data-setup interval is setupCount+1 ticks |
| filterLen | input | 4 | Glitch filter length in clocks (0 = bypass) |
| dataValid | input | 1 | Next data bit is available |
| dataBit | input | 1 | Next data bit value |
| sclOe | output | 1 | Pull clock line low when 1 |
| sdaOe | output | 1 | Pull data line low when 1 |
| bitTaken | output | 1 | One-cycle pulse when a bit is placed on the data line |

## Verification
Each result has a fixed due cycle relative to its stimulus. The clock pull is due 3+F cycles after the line drop is applied. The data change and taken pulse are due H*(P+1)+1 cycles after the pull, or one cycle after late data is supplied. The release is due (S+1)*(P+1)+1 cycles after the taken pulse. The stimulus task computes each due cycle from these formulas as it applies the stimulus, and queues the cycle with the expected line level. A monitor samples at the falling clock edge, turns every change of the clock pull and every taken pulse into an event, and matches it against the head of the queue for both cycle and value. An event that arrives early, late, twice or unrequested is therefore reported.

// File: rtl/bit_timer_pkg.sv
package bit_timer_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_HOLD  = 2'd1,
    PH_SETUP = 2'd2,
    PH_WAITHI = 2'd3
  } phase_e;

  typedef struct packed {
    logic loadHold;
    logic loadSetup;
  } timer_cmd_t;

endpackage

// File: rtl/bit_timer_datapath.sv
module bit_timer_datapath
  import bit_timer_pkg::*;
#(
  parameter int CFG_W       = 4,
  parameter int SYNC_STAGES = 2,
  parameter bit FILTER_EN   = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic [CFG_W-1:0] prescale,
  input  logic [CFG_W-1:0] holdCount,
  input  logic [CFG_W-1:0] setupCount,
  input  logic [CFG_W-1:0] filterLen,
  input  timer_cmd_t       cmd,
  output logic             sclFall,
  output logic             sclHigh,
  output logic             timerDone
);

  localparam int UNIT_W = CFG_W + 1;

  // Input synchronizer, reset to the idle-high bus level
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   syncLevel;

  always_ff @(posedge clk) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], sclIn};
  end
  assign syncLevel = syncQ[SYNC_STAGES-1];

  // Glitch filter: a new level passes only after filterLen steady clocks
  logic sclLevel;

  generate
    if (FILTER_EN) begin : g_filter
      logic [CFG_W-1:0] runCnt;
      logic             filtQ;

      always_ff @(posedge clk) begin
        if (!rstN) begin
          filtQ  <= 1'b1;
          runCnt <= '0;
        end else if (filterLen == '0 || syncLevel == filtQ) begin
          filtQ  <= syncLevel;
          runCnt <= '0;
        end else if (runCnt == filterLen - 1'b1) begin
          filtQ  <= syncLevel;
          runCnt <= '0;
        end else begin
          runCnt <= runCnt + 1'b1;
        end
      end

      assign sclLevel = (filterLen == '0) ? syncLevel : filtQ;
    end else begin : g_nofilter
      assign sclLevel = syncLevel;
    end
  endgenerate

  // Edge detection on the conditioned level
  logic levelQ;

  always_ff @(posedge clk) begin
    if (!rstN) levelQ <= 1'b1;
    else       levelQ <= sclLevel;
  end

  assign sclFall = levelQ & ~sclLevel;
  assign sclHigh = sclLevel;

  // Prescaled interval timer
  logic [UNIT_W-1:0] unitQ;
  logic [CFG_W-1:0]  preQ;
  logic              tick;

  assign tick = (preQ == prescale);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      unitQ <= '0;
      preQ  <= '0;
    end else if (cmd.loadHold) begin
      unitQ <= {1'b0, holdCount};
      preQ  <= '0;
    end else if (cmd.loadSetup) begin
      unitQ <= {1'b0, setupCount} + UNIT_W'(1);
      preQ  <= '0;
    end else if (unitQ != '0) begin
      if (tick) begin
        preQ  <= '0;
        unitQ <= unitQ - 1'b1;
      end else begin
        preQ  <= preQ + 1'b1;
      end
    end
  end

  assign timerDone = (unitQ == '0);

endmodule

// File: rtl/bit_timer_control.sv
module bit_timer_control
  import bit_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclFall,
  input  logic       sclHigh,
  input  logic       timerDone,
  input  logic       dataValid,
  input  logic       dataBit,
  output timer_cmd_t cmd,
  output logic       sclOe,
  output logic       sdaOe,
  output logic       bitTaken
);

  phase_e phaseQ, phaseD;
  logic   takeBit;
  logic   releaseScl;
  logic   startLow;

  always_comb begin
    phaseD        = phaseQ;
    cmd           = '0;
    takeBit       = 1'b0;
    releaseScl    = 1'b0;
    startLow      = 1'b0;
    unique case (phaseQ)
      PH_IDLE: begin
        if (sclFall) begin
          startLow     = 1'b1;
          cmd.loadHold = 1'b1;
          phaseD       = PH_HOLD;
        end
      end
      PH_HOLD: begin
        // stay here, stretching the clock, until the bit is supplied
        if (timerDone && dataValid) begin
          takeBit       = 1'b1;
          cmd.loadSetup = 1'b1;
          phaseD        = PH_SETUP;
        end
      end
      PH_SETUP: begin
        if (timerDone) begin
          releaseScl = 1'b1;
          phaseD     = PH_WAITHI;
        end
      end
      PH_WAITHI: begin
        // another device may still hold the line low
        if (sclHigh) phaseD = PH_IDLE;
      end
      default: phaseD = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseQ   <= PH_IDLE;
      sclOe    <= 1'b0;
      sdaOe    <= 1'b0;
      bitTaken <= 1'b0;
    end else begin
      phaseQ   <= phaseD;
      bitTaken <= takeBit;
      if (startLow)        sclOe <= 1'b1;
      else if (releaseScl) sclOe <= 1'b0;
      if (takeBit) sdaOe <= ~dataBit;
    end
  end

endmodule

// File: rtl/i2c_bit_timer.sv
module i2c_bit_timer
  import bit_timer_pkg::*;
#(
  parameter int CFG_W       = 4,
  parameter int SYNC_STAGES = 2,
  parameter bit FILTER_EN   = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic [CFG_W-1:0] prescale,
  input  logic [CFG_W-1:0] holdCount,
  input  logic [CFG_W-1:0] setupCount,
  input  logic [CFG_W-1:0] filterLen,
  input  logic             dataValid,
  input  logic             dataBit,
  output logic             sclOe,
  output logic             sdaOe,
  output logic             bitTaken
);

  timer_cmd_t cmd;
  logic       sclFall;
  logic       sclHigh;
  logic       timerDone;

  bit_timer_datapath #(
    .CFG_W      (CFG_W),
    .SYNC_STAGES(SYNC_STAGES),
    .FILTER_EN  (FILTER_EN)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .sclIn     (sclIn),
    .prescale  (prescale),
    .holdCount (holdCount),
    .setupCount(setupCount),
    .filterLen (filterLen),
    .cmd       (cmd),
    .sclFall   (sclFall),
    .sclHigh   (sclHigh),
    .timerDone (timerDone)
  );

  bit_timer_control u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .sclFall  (sclFall),
    .sclHigh  (sclHigh),
    .timerDone(timerDone),
    .dataValid(dataValid),
    .dataBit  (dataBit),
    .cmd      (cmd),
    .sclOe    (sclOe),
    .sdaOe    (sdaOe),
    .bitTaken (bitTaken)
  );

endmodule

// File: rtl/i2c_bit_timer_chk.sv
module i2c_bit_timer_chk #(
  parameter int CFG_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic [CFG_W-1:0] prescale,
  input logic [CFG_W-1:0] holdCount,
  input logic [CFG_W-1:0] setupCount,
  input logic             sclOe,
  input logic             sdaOe,
  input logic             bitTaken
);

  logic        oeQ;
  logic [15:0] sinceLow;
  logic [15:0] sinceTaken;
  logic [15:0] holdNeed;
  logic [15:0] setupNeed;

  assign holdNeed  = 16'(holdCount) * (16'(prescale) + 16'd1) + 16'd1;
  assign setupNeed = (16'(setupCount) + 16'd1) * (16'(prescale) + 16'd1) + 16'd1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      oeQ        <= 1'b0;
      sinceLow   <= '0;
      sinceTaken <= '0;
    end else begin
      oeQ <= sclOe;
      if (sclOe && !oeQ)          sinceLow <= 16'd1;
      else if (sinceLow != '1)    sinceLow <= sinceLow + 16'd1;
      if (bitTaken)               sinceTaken <= 16'd1;
      else if (sinceTaken != '1)  sinceTaken <= sinceTaken + 16'd1;
    end
  end

  a_r1_reset_release: assert property (@(posedge clk)
    !rstN |=> (!sclOe && !sdaOe && !bitTaken));

  a_r6_taken_pulse: assert property (@(posedge clk) disable iff (!rstN)
    bitTaken |=> !bitTaken);

  a_r6_taken_while_low: assert property (@(posedge clk) disable iff (!rstN)
    bitTaken |-> sclOe);

  a_r5_sda_only_on_take: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> bitTaken);

  a_r4_hold_window: assert property (@(posedge clk) disable iff (!rstN)
    bitTaken |-> (sinceLow >= holdNeed));

  a_r7_setup_window: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sclOe) |-> (sinceTaken == setupNeed));

endmodule

bind i2c_bit_timer i2c_bit_timer_chk #(.CFG_W(CFG_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .prescale  (prescale),
  .holdCount (holdCount),
  .setupCount(setupCount),
  .sclOe     (sclOe),
  .sdaOe     (sdaOe),
  .bitTaken  (bitTaken)
);

// File: tb/sim_i2c_bit_timer.sv
`timescale 1ns/1ps
module sim_i2c_bit_timer;

  logic       clk = 1'b0;
  logic       rstN;
  logic       extPull;
  logic       dataValid;
  logic       dataBit;
  logic [3:0] prescale, holdCount, setupCount, filterLen;
  logic       sclIn;
  logic       sclOe, sdaOe, bitTaken;

  always #2.5 clk = ~clk;

  assign sclIn = !(sclOe || extPull);

  i2c_bit_timer u0 (
    .clk(clk), .rstN(rstN), .sclIn(sclIn),
    .prescale(prescale), .holdCount(holdCount),
    .setupCount(setupCount), .filterLen(filterLen),
    .dataValid(dataValid), .dataBit(dataBit),
    .sclOe(sclOe), .sdaOe(sdaOe), .bitTaken(bitTaken)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int errors = 0;
  int checks = 0;
  bit monOn = 1'b0;
  bit done = 1'b0;
  bit lastSda = 1'b0;

  // expected event queue: kind 0 = pull starts, 1 = bit taken, 2 = release
  int    qKind[$];
  int    qCyc[$];
  bit    qVal[$];
  string qReq[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic void pushEv(input int k, input int c, input bit v, input string r);
    qKind.push_back(k);
    qCyc.push_back(c);
    qVal.push_back(v);
    qReq.push_back(r);
  endfunction

  task automatic handleEv(input int k, input int c, input bit v);
    int    ek, ec;
    bit    ev;
    string er;
    if (qKind.size() == 0) begin
      chk(1'b0, "R9", "unexpected event kind", k, -1);
    end else begin
      ek = qKind.pop_front();
      ec = qCyc.pop_front();
      ev = qVal.pop_front();
      er = qReq.pop_front();
      chk(ek == k, er, "event kind", k, ek);
      chk(ec == c, er, "event cycle", c, ec);
      if (k == 1) chk(ev == v, "R5", "sdaOe at bit taken", int'(v), int'(ev));
    end
  endtask

  // monitor
  initial begin
    bit prevOe;
    prevOe = 1'b0;
    forever begin
      @(negedge clk);
      if (monOn) begin
        if (sclOe !== prevOe) handleEv(sclOe ? 0 : 2, cyc, 1'b0);
        if (bitTaken === 1'b1) handleEv(1, cyc, sdaOe);
      end
      prevOe = sclOe;
    end
  end

  task automatic waitCyc(input int x);
    while (cyc < x) @(negedge clk);
  endtask

  task automatic doBit(input bit b, input bit late);
    int c, r, t, fc, v, hp;
    @(negedge clk);
    hp = int'(prescale) + 1;
    dataBit   = b;
    dataValid = !late;
    c = cyc;
    extPull = 1'b1;
    r = c + 3 + int'(filterLen);
    pushEv(0, r, 1'b0, "R2");
    t = 0;
    if (!late) begin
      t = r + int'(holdCount) * hp + 1;
      pushEv(1, t, !b, "R4");
    end
    waitCyc(r);
    extPull = 1'b0;
    if (late) begin
      v = r + int'(holdCount) * hp + 5;
      waitCyc(v);
      chk(sclOe == 1'b1, "R8", "clock held while data late", int'(sclOe), 1);
      chk(sdaOe == lastSda, "R8", "sda unchanged while data late", int'(sdaOe), int'(lastSda));
      dataValid = 1'b1;
      t = v + 1;
      pushEv(1, t, !b, "R8");
    end
    fc = t + (int'(setupCount) + 1) * hp + 1;
    pushEv(2, fc, 1'b0, "R7");
    waitCyc(t + 1);
    chk(bitTaken == 1'b0, "R6", "taken pulse one cycle", int'(bitTaken), 0);
    waitCyc(fc + 25);
    dataValid = 1'b0;
    lastSda = !b;
  endtask

  task automatic cfg(input int p, input int h, input int s, input int f);
    @(negedge clk);
    prescale   = 4'(p);
    holdCount  = 4'(h);
    setupCount = 4'(s);
    filterLen  = 4'(f);
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      finishRun();
    end
  end

  initial begin
    int c, r, t, fc, hp;
    rstN = 1'b0; extPull = 1'b0; dataValid = 1'b0; dataBit = 1'b1;
    prescale = '0; holdCount = '0; setupCount = '0; filterLen = '0;
    repeat (3) @(negedge clk);
    chk(sclOe == 1'b0, "R1", "sclOe in reset", int'(sclOe), 0);
    chk(sdaOe == 1'b0, "R1", "sdaOe in reset", int'(sdaOe), 0);
    chk(bitTaken == 1'b0, "R1", "bitTaken in reset", int'(bitTaken), 0);
    rstN = 1'b1;
    monOn = 1'b1;
    repeat (5) @(negedge clk);

    // minimum delays
    cfg(0, 0, 0, 0);
    doBit(1'b0, 1'b0);
    doBit(1'b1, 1'b0);

    // prescaled hold and setup
    cfg(2, 3, 1, 0);
    doBit(1'b0, 1'b0);
    doBit(1'b1, 1'b0);

    // filtered input, then late data (R8)
    cfg(1, 2, 4, 3);
    doBit(1'b0, 1'b0);
    doBit(1'b1, 1'b1);

    // R3: short glitch is filtered out
    cfg(0, 1, 0, 4);
    @(negedge clk);
    extPull = 1'b1;
    repeat (3) @(negedge clk);
    extPull = 1'b0;
    repeat (20) @(negedge clk);
    chk(sclOe == 1'b0, "R3", "glitch ignored", int'(sclOe), 0);
    doBit(1'b0, 1'b0);

    // R9: another device keeps the clock low after release
    cfg(0, 1, 1, 0);
    @(negedge clk);
    hp = int'(prescale) + 1;
    dataBit = 1'b1; dataValid = 1'b1;
    c = cyc;
    extPull = 1'b1;
    r = c + 3;
    pushEv(0, r, 1'b0, "R2");
    t = r + int'(holdCount) * hp + 1;
    pushEv(1, t, 1'b0, "R4");
    fc = t + (int'(setupCount) + 1) * hp + 1;
    pushEv(2, fc, 1'b0, "R7");
    waitCyc(fc + 30);
    chk(sclOe == 1'b0, "R9", "no new phase while held low", int'(sclOe), 0);
    chk(qKind.size() == 0, "R9", "events pending", qKind.size(), 0);
    extPull = 1'b0;
    dataValid = 1'b0;
    lastSda = 1'b0;
    waitCyc(fc + 60);
    doBit(1'b0, 1'b0);

    // largest settings
    cfg(15, 15, 15, 0);
    doBit(1'b0, 1'b0);

    // R1: reset in the middle of a stretched bit
    cfg(1, 2, 1, 0);
    @(negedge clk);
    dataValid = 1'b0;
    c = cyc;
    extPull = 1'b1;
    r = c + 3;
    pushEv(0, r, 1'b0, "R2");
    waitCyc(r);
    extPull = 1'b0;
    waitCyc(r + 4);
    rstN = 1'b0;
    pushEv(2, r + 5, 1'b0, "R1");
    waitCyc(r + 5);
    chk(sdaOe == 1'b0, "R1", "sdaOe cleared by reset", int'(sdaOe), 0);
    chk(bitTaken == 1'b0, "R1", "bitTaken cleared by reset", int'(bitTaken), 0);
    waitCyc(r + 7);
    rstN = 1'b1;
    lastSda = 1'b0;
    repeat (10) @(negedge clk);
    doBit(1'b1, 1'b0);

    repeat (20) @(negedge clk);
    chk(qKind.size() == 0, "R7", "events left at end", qKind.size(), 0);
    done = 1'b1;
    finishRun();
  end

endmodule